// File: doc/BRIEF.md
# Port Bit-Change Detector

This block keeps a snapshot of an 8-bit port and, whenever a sample strobe arrives, compares the port's present value with that snapshot. From the comparison it produces three masks: one marking every bit that differs, one marking the bits that dropped from one to zero, and one marking the bits that climbed from zero to one. The sampled value itself is reported with the masks, and the sample then becomes the snapshot for the next comparison.

A small two-state sequencer paces the results. In state `SEQ_IDLE` nothing new is being shown. A strobe takes the transition `idle_to_report` (or `report_to_report` when strobes come back to back), and while in `SEQ_REPORT` the valid output is high for exactly that cycle. Without a strobe, `report_to_idle` returns the sequencer to `SEQ_IDLE`, and `idle_hold` keeps it there. The registered outputs keep their last values between strobes, so a consumer may read them at any time after a valid pulse.

Top module: `port_change_detector`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the first cycle after it, `valid_o`, `value_o`, `change_o`, `fall_o` and `rise_o` are all zero, and the stored snapshot is zero, so the first strobe compares against 0x00.
- R2: On a result, bit i of `change_o` is one exactly when bit i of the sampled port differs from bit i of the snapshot taken at the previous strobe.
- R3: On a result, bit i of `fall_o` is one exactly when bit i changed and the snapshot held a one in that position.
- R4: On a result, bit i of `rise_o` is one exactly when bit i changed and the new sample holds a one in that position.
- R5: Every strobe replaces the snapshot with the sampled value; the following strobe compares against it.
- R6: A strobe high in the cycle before clock edge k makes `valid_o` high for the cycle after edge k; `valid_o` is low after any edge not preceded by a strobe, and back-to-back strobes give a valid in every cycle.
- R7: `fall_o` and `rise_o` never share a set bit, and their bitwise OR equals `change_o`.
- R8: Without a strobe, all outputs hold their values and port activity has no effect on outputs or on the snapshot.
- R9: On a result, `value_o` equals the port value present in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe; compare on this cycle |
| port_i | input | 8 | Port value being watched |
| valid_o | output | 1 | One-cycle pulse marking fresh results |
| value_o | output | 8 | Port value taken at the last strobe |
| change_o | output | 8 | Bits that differ from the previous snapshot |
| fall_o | output | 8 | Bits that went from one to zero |
| rise_o | output | 8 | Bits that went from zero to one |

## Verification
On every cycle the assertions check the pacing of the valid pulse against the strobe, that the snapshot and the reported value follow the sampled port, that the falling and rising masks are disjoint and together cover the change mask, and that outputs stay still when no strobe came. Whether each mask marks the correct bits against the true history of samples, the state right after reset, and the fact that unstrobed port activity does not leak into the next comparison are shown only by the bench's sequences, which track the expected snapshot independently.

// File: rtl/cd_pkg.sv
package cd_pkg;

    // Default port width.
    parameter int DEF_WIDTH = 8;

    // Sequencer states.
    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_REPORT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cd_snapshot.sv
module cd_snapshot #(
    parameter int WIDTH = cd_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] prev_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_o <= '0;
        end else if (load_i) begin
            prev_o <= data_i;
        end
    end

    AST_SNAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> prev_o == $past(data_i)); // R5

    AST_SNAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(prev_o)); // R8

endmodule

// File: rtl/cd_mask_calc.sv
module cd_mask_calc #(
    parameter int WIDTH = cd_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] prev_i,
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] change_o,
    output logic [WIDTH-1:0] fall_o,
    output logic [WIDTH-1:0] rise_o
);

    // Per-bit comparison, one slice per port line.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            change_o[b] = prev_i[b] ^ cur_i[b];
            fall_o[b]   = change_o[b] & prev_i[b];
            rise_o[b]   = change_o[b] & cur_i[b];
        end
    end

endmodule

// File: rtl/cd_seq.sv
module cd_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    output logic load_o,
    output logic valid_o
);
    import cd_pkg::*;

    seq_state_e state_q, state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   state_d = sample_i ? SEQ_REPORT : SEQ_IDLE;   // idle_to_report / idle_hold
            SEQ_REPORT: state_d = sample_i ? SEQ_REPORT : SEQ_IDLE;   // report_to_report / report_to_idle
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        load_o  = sample_i;
        valid_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   valid_o = 1'b0;
            SEQ_REPORT: valid_o = 1'b1;
            default:    valid_o = 1'b0;
        endcase
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> valid_o); // R6

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> !valid_o); // R6

endmodule

// File: rtl/cd_result.sv
module cd_result #(
    parameter int WIDTH = cd_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] value_i,
    input  logic [WIDTH-1:0] change_i,
    input  logic [WIDTH-1:0] fall_i,
    input  logic [WIDTH-1:0] rise_i,
    output logic [WIDTH-1:0] value_o,
    output logic [WIDTH-1:0] change_o,
    output logic [WIDTH-1:0] fall_o,
    output logic [WIDTH-1:0] rise_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_o  <= '0;
            change_o <= '0;
            fall_o   <= '0;
            rise_o   <= '0;
        end else if (load_i) begin
            value_o  <= value_i;
            change_o <= change_i;
            fall_o   <= fall_i;
            rise_o   <= rise_i;
        end
    end

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(value_o) && $stable(change_o)
                     && $stable(fall_o) && $stable(rise_o))); // R8

endmodule

// File: rtl/port_change_detector.sv
module port_change_detector #(
    parameter int WIDTH = cd_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic [WIDTH-1:0] port_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] value_o,
    output logic [WIDTH-1:0] change_o,
    output logic [WIDTH-1:0] fall_o,
    output logic [WIDTH-1:0] rise_o
);

    localparam int MW = WIDTH;

    logic          load;
    logic [MW-1:0] prev;
    logic [MW-1:0] chg_c, fall_c, rise_c;

    cd_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .load_o   (load),
        .valid_o  (valid_o)
    );

    cd_snapshot #(.WIDTH(MW)) i_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .data_i (port_i),
        .prev_o (prev)
    );

    cd_mask_calc #(.WIDTH(MW)) i_calc (
        .prev_i   (prev),
        .cur_i    (port_i),
        .change_o (chg_c),
        .fall_o   (fall_c),
        .rise_o   (rise_c)
    );

    cd_result #(.WIDTH(MW)) i_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .value_i  (port_i),
        .change_i (chg_c),
        .fall_i   (fall_c),
        .rise_i   (rise_c),
        .value_o  (value_o),
        .change_o (change_o),
        .fall_o   (fall_o),
        .rise_o   (rise_o)
    );

    AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o & rise_o) == '0); // R7

    AST_MASKS_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o | rise_o) == change_o); // R7

    AST_VALUE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> value_o == $past(port_i)); // R9

    AST_RISE_IS_NEW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & ~value_o) == '0); // R4

endmodule

// File: tb/test_port_change_detector.sv
`timescale 1ns/1ps
module test_port_change_detector;

    localparam int W = 8;
    localparam int NV = 10;
    localparam logic [W-1:0] VEC [NV] = '{
        8'h5A, 8'h5A, 8'hA5, 8'hFF, 8'h00,
        8'h81, 8'h7E, 8'h0F, 8'hF0, 8'h3C
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_i = 1'b0;
    logic [W-1:0] port_i = '0;
    logic         valid_o;
    logic [W-1:0] value_o, change_o, fall_o, rise_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [W-1:0] model_prev = '0;

    always #2.5 clk = ~clk;

    port_change_detector #(.WIDTH(W)) i_port_change_detector (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .port_i(port_i),
        .valid_o(valid_o), .value_o(value_o), .change_o(change_o),
        .fall_o(fall_o), .rise_o(rise_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check all outputs against model for a fresh result of sample v.
    task automatic check_result(input logic [W-1:0] v);
        logic [W-1:0] c;
        c = model_prev ^ v;
        chk("R6 valid", {7'd0, valid_o}, 8'd1);
        chk("R9 value", value_o, v);
        chk("R2 change", change_o, c);
        chk("R3 fall", fall_o, c & model_prev);
        chk("R4 rise", rise_o, c & v);
        chk("R7 disjoint", fall_o & rise_o, 8'h00);
        chk("R7 cover", fall_o | rise_o, change_o);
        model_prev = v; // R5
    endtask

    task automatic strobe(input logic [W-1:0] v);
        port_i = v;
        sample_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_i = 1'b0;
        check_result(v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] hv, hc, hf, hr;
        port_i = 8'hC3;
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        chk("R1 valid in reset", {7'd0, valid_o}, 8'd0);
        chk("R1 value in reset", value_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 change after reset", change_o, 8'h00);
        chk("R1 fall after reset", fall_o, 8'h00);
        chk("R1 rise after reset", rise_o, 8'h00);
        chk("R1 valid after reset", {7'd0, valid_o}, 8'd0);

        // Table walk; first strobe compares against zero (R1, R5)
        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i]);
            chk("R6 pulse ends", {7'd0, valid_o}, 8'd1);
            @(negedge clk);
            chk("R6 single pulse", {7'd0, valid_o}, 8'd0);
        end

        // R8: port activity without strobe ignored
        hv = value_o; hc = change_o; hf = fall_o; hr = rise_o;
        port_i = 8'hFF; @(negedge clk);
        port_i = 8'h00; @(negedge clk);
        port_i = 8'h99; @(negedge clk);
        chk("R8 value hold", value_o, hv);
        chk("R8 change hold", change_o, hc);
        chk("R8 fall hold", fall_o, hf);
        chk("R8 rise hold", rise_o, hr);
        chk("R8 no valid", {7'd0, valid_o}, 8'd0);
        // Snapshot untouched: next strobe compares against last strobed value (R5, R8)
        strobe(8'h3C);
        chk("R8 snapshot untouched", change_o, 8'h00);

        // R6: back-to-back strobes
        port_i = 8'h01; sample_i = 1'b1;
        @(posedge clk); @(negedge clk);
        check_result(8'h01);
        port_i = 8'h03;
        @(posedge clk); @(negedge clk);
        check_result(8'h03);
        port_i = 8'h02;
        @(posedge clk); @(negedge clk);
        sample_i = 1'b0;
        check_result(8'h02);
        @(negedge clk);
        chk("R6 valid drops", {7'd0, valid_o}, 8'd0);

        // R1: reset mid-run clears snapshot
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 value cleared", value_o, 8'h00);
        chk("R1 change cleared", change_o, 8'h00);
        rst_n = 1'b1;
        model_prev = '0;
        @(negedge clk);
        strobe(8'h80);
        chk("R1 compare vs zero", rise_o, 8'h80);

        finish_run();
    end

endmodule